// File: doc/BRIEF.md
# External Interrupt Detector

This block watches two banks of sixteen external input pins and turns activity on one chosen pin per bank into an interrupt-pending flag. Each of the two channels is steered by one byte of a 32-bit control word. That byte chooses the pin, the active polarity, the detection style (level, single edge or both edges) and whether the channel is armed at all. Software writes the word through a plain write strobe and can read it back at any time.

Every pin is brought into the clock domain through a two-stage synchronizer before any decision is made. Edge detection compares the synchronized value of the chosen pin with its value one cycle earlier. When the pin choice changes, the one-cycle-old sample is reloaded from the newly chosen pin, so a switch of pins never looks like an edge. In the edge styles the pending flag stays set until a write-one-to-clear strobe removes it. In level style the flag simply tracks the qualified level.

Top module: `exti_detect`

## Requirements
- R1: After reset the control word reads as zero and both pending flags are low.
- R2: A cycle with `cfg_wr_en` high loads bits [15:0] of `cfg_wdata` into the control word, effective from the next cycle. `cfg_rdata` always returns the stored bits, with bits [31:16] reading zero. Channel c owns byte c: pin select in bits [8c+3:8c], polarity in bit 8c+4, mode in bits [8c+6:8c+5], enable in bit 8c+7.
- R3: Channel c observes only `pin_bus[16c+k]`, where k is its select value. Activity on any other pin leaves its flag unchanged.
- R4: A pin change driven between clock edges reaches the pending flag at the third rising edge after it, and not earlier.
- R5: In mode 0 (level), an enabled channel's flag is high while the pin equals the polarity bit (1 = high, 0 = low). The flag drops once the pin leaves that level.
- R6: In mode 0, a clear strobe does not lower the flag while the qualifying level persists.
- R7: In mode 1 (single edge), polarity 1 sets the flag on a rising edge and polarity 0 on a falling edge; the opposite edge does nothing. Once set, the flag stays high without a clear.
- R8: In mode 2 (dual edge), both rising and falling edges set the flag, whatever the polarity bit holds.
- R9: In edge modes, a one-cycle `pend_clr[c]` pulse lowers the flag at the next edge. If a new edge is detected in the same cycle as the clear, the flag stays set.
- R10: A channel whose enable bit is 0, or whose mode is 3, holds its flag low from the cycle after that setting takes effect.
- R11: Rewriting the pin select never sets the flag by itself, even when the old and new pins sit at different levels.
- R12: The two channels are independent: configuration, pins and clear strobes of one channel do not change the other's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Load control word this cycle |
| cfg_wdata | input | 32 | Control word to load |
| cfg_rdata | output | 32 | Current control word |
| pend_clr | input | 2 | Write-one-to-clear strobe, one bit per channel |
| pin_bus | input | 32 | Raw external pins, 16 per channel, channel 0 in the low half |
| irq_pend | output | 2 | Interrupt-pending flag per channel |

## Verification
The embedded properties check, on every cycle, that writes land in the control word and that the word holds without a write. They also check that a disarmed or reserved-mode channel keeps its flag low, that edge flags are sticky until cleared, and that a qualifying edge always sets the flag in the following cycle. Only the bench scenarios can show the end-to-end timing from a raw pin to the flag through the synchronizer. The same holds for the absence of a false edge on a pin switch, for pin isolation inside a bank and across channels, and for set-over-clear priority, because each of these depends on a specific sequence of pin values.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int PINS_PER_CH = 16;
  localparam int SEL_W       = $clog2(PINS_PER_CH);
  localparam int CH_FIELD_W  = 8;

  typedef enum logic [1:0] {
    MODE_LEVEL = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_RSVD  = 2'd3
  } det_mode_e;

  // Byte layout per channel, MSB first: enable, mode, polarity, select
  typedef struct packed {
    logic             en;
    det_mode_e        mode;
    logic             pol;
    logic [SEL_W-1:0] sel;
  } chan_cfg_t;
endpackage

// File: rtl/exti_sync_bank.sv
module exti_sync_bank #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/exti_ctrl_reg.sv
module exti_ctrl_reg
  import exti_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int REG_W  = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output chan_cfg_t [NUM_CH-1:0]      cfg_o,
  output logic [NUM_CH-1:0]           sel_load_o,
  output logic [NUM_CH-1:0][SEL_W-1:0] sel_next_o
);
  localparam int USED_W = NUM_CH * CH_FIELD_W;

  logic [USED_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wdata[USED_W-1:0];
  end

  always_comb begin
    rdata = '0;
    rdata[USED_W-1:0] = ctrl_q;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_field
    assign cfg_o[c]      = chan_cfg_t'(ctrl_q[c*CH_FIELD_W +: CH_FIELD_W]);
    assign sel_next_o[c] = wdata[c*CH_FIELD_W +: SEL_W];
    assign sel_load_o[c] = wr_en &&
                           (wdata[c*CH_FIELD_W +: SEL_W] != ctrl_q[c*CH_FIELD_W +: SEL_W]);
  end

  if (USED_W < REG_W) begin : g_spare
    logic unused_hi;
    assign unused_hi = ^wdata[REG_W-1:USED_W];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata[USED_W-1:0] == $past(wdata[USED_W-1:0])); // R2
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rdata)); // R2
endmodule

// File: rtl/exti_channel.sv
module exti_channel
  import exti_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  chan_cfg_t              cfg,
  input  logic                   sel_load,
  input  logic [SEL_W-1:0]       sel_next,
  input  logic [PINS_PER_CH-1:0] pins_raw,
  input  logic                   clr,
  output logic                   pend
);
  logic [PINS_PER_CH-1:0] pins_sync;
  logic cur_s;
  logic prev_q;
  logic pend_q;
  logic rise_s, fall_s;
  logic active_s;
  logic edge_hit;
  logic pend_nxt;

  exti_sync_bank #(.WIDTH(PINS_PER_CH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pins_raw),
    .sync_o (pins_sync)
  );

  assign cur_s  = pins_sync[cfg.sel];
  assign rise_s = cur_s & ~prev_q;
  assign fall_s = ~cur_s & prev_q;
  assign active_s = cfg.en && (cfg.mode != MODE_RSVD);

  // Reload the history from the incoming pin so a pin switch is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n)        prev_q <= 1'b0;
    else if (sel_load) prev_q <= pins_sync[sel_next];
    else               prev_q <= cur_s;
  end

  always_comb begin
    unique case (cfg.mode)
      MODE_EDGE: edge_hit = cfg.pol ? rise_s : fall_s;
      MODE_BOTH: edge_hit = rise_s | fall_s;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    if (!active_s)                   pend_nxt = 1'b0;
    else if (cfg.mode == MODE_LEVEL) pend_nxt = (cur_s == cfg.pol);
    else                             pend_nxt = edge_hit | (pend_q & ~clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_nxt;
  end

  assign pend = pend_q;

  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active_s |=> !pend); // R10
  AST_LEVEL_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (active_s && cfg.mode == MODE_LEVEL && cur_s == cfg.pol && clr) |=> pend); // R6
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (active_s && cfg.mode != MODE_LEVEL && pend && !clr) |=> pend); // R7
  AST_SINGLE_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.mode == MODE_EDGE && ((cfg.pol && rise_s) || (!cfg.pol && fall_s))) |=> pend); // R7
  AST_DUAL_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.mode == MODE_BOTH && (rise_s || fall_s)) |=> pend); // R8
endmodule

// File: rtl/exti_detect.sv
module exti_detect
  import exti_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int REG_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr_en,
  input  logic [REG_W-1:0]              cfg_wdata,
  output logic [REG_W-1:0]              cfg_rdata,
  input  logic [NUM_CH-1:0]             pend_clr,
  input  logic [NUM_CH*PINS_PER_CH-1:0] pin_bus,
  output logic [NUM_CH-1:0]             irq_pend
);
  chan_cfg_t [NUM_CH-1:0]         cfg_w;
  logic [NUM_CH-1:0]              sel_load_w;
  logic [NUM_CH-1:0][SEL_W-1:0]   sel_next_w;

  exti_ctrl_reg #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .cfg_o      (cfg_w),
    .sel_load_o (sel_load_w),
    .sel_next_o (sel_next_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    exti_channel u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg_w[c]),
      .sel_load (sel_load_w[c]),
      .sel_next (sel_next_w[c]),
      .pins_raw (pin_bus[c*PINS_PER_CH +: PINS_PER_CH]),
      .clr      (pend_clr[c]),
      .pend     (irq_pend[c])
    );
  end
endmodule

// File: tb/exti_detect_bench.sv
module exti_detect_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [1:0]  pend_clr;
  logic [31:0] pin_bus;
  logic [1:0]  irq_pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exti_detect u_exti_detect (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pend_clr(pend_clr), .pin_bus(pin_bus), .irq_pend(irq_pend)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] fld(int sel, bit pol, int mode, bit en);
    return {en, mode[1:0], pol, sel[3:0]};
  endfunction

  task automatic wr(logic [31:0] d);
    cfg_wr_en = 1'b1; cfg_wdata = d;
    tick(1);
    cfg_wr_en = 1'b0; cfg_wdata = '0;
  endtask

  task automatic clr(int ch);
    pend_clr[ch] = 1'b1;
    tick(1);
    pend_clr = '0;
  endtask

  task automatic quiesce();
    wr(32'h0);
    pin_bus = '0;
    tick(4);
  endtask

  task automatic t_reset();
    check("R1", "control after reset", cfg_rdata, 32'h0);
    check("R1", "pending after reset", {30'h0, irq_pend}, 32'h0);
  endtask

  task automatic t_regs();
    wr(32'hFFFF_FFFF);
    check("R2", "upper bits read zero", cfg_rdata, 32'h0000_FFFF);
    wr(32'hABCD_1234);
    check("R2", "readback pattern", cfg_rdata, 32'h0000_1234);
    quiesce();
  endtask

  task automatic t_level();
    wr({24'h0, fld(5, 1, 0, 1)});
    tick(2);
    check("R5", "level idle", {31'h0, irq_pend[0]}, 32'h0);
    pin_bus[5] = 1'b1;
    tick(2);
    check("R4", "not before third edge", {31'h0, irq_pend[0]}, 32'h0);
    tick(1);
    check("R4", "at third edge", {31'h0, irq_pend[0]}, 32'h1);
    clr(0);
    check("R6", "clear ignored under level", {31'h0, irq_pend[0]}, 32'h1);
    pin_bus[5] = 1'b0;
    tick(3);
    check("R5", "drops with level", {31'h0, irq_pend[0]}, 32'h0);
    wr({24'h0, fld(5, 0, 0, 1)});
    tick(1);
    check("R5", "low polarity level", {31'h0, irq_pend[0]}, 32'h1);
    quiesce();
  endtask

  task automatic t_edge();
    wr({24'h0, fld(3, 1, 1, 1)});
    pin_bus[3] = 1'b1;
    tick(3);
    check("R7", "rising sets", {31'h0, irq_pend[0]}, 32'h1);
    pin_bus[3] = 1'b0;
    tick(3);
    check("R7", "sticky", {31'h0, irq_pend[0]}, 32'h1);
    clr(0);
    check("R9", "clear lowers", {31'h0, irq_pend[0]}, 32'h0);
    wr({24'h0, fld(3, 0, 1, 1)});
    pin_bus[3] = 1'b1;
    tick(3);
    check("R7", "rising ignored at pol 0", {31'h0, irq_pend[0]}, 32'h0);
    pin_bus[3] = 1'b0;
    tick(3);
    check("R7", "falling sets at pol 0", {31'h0, irq_pend[0]}, 32'h1);
    quiesce();
  endtask

  task automatic t_dual();
    wr({24'h0, fld(4, 0, 2, 1)});
    pin_bus[4] = 1'b1;
    tick(3);
    check("R8", "rise with pol 0", {31'h0, irq_pend[0]}, 32'h1);
    clr(0);
    wr({24'h0, fld(4, 1, 2, 1)});
    pin_bus[4] = 1'b0;
    tick(3);
    check("R8", "fall with pol 1", {31'h0, irq_pend[0]}, 32'h1);
    pin_bus[4] = 1'b1;
    tick(2);
    pend_clr[0] = 1'b1;
    tick(1);
    pend_clr = '0;
    check("R9", "edge beats clear", {31'h0, irq_pend[0]}, 32'h1);
    clr(0);
    check("R9", "later clear", {31'h0, irq_pend[0]}, 32'h0);
    quiesce();
  endtask

  task automatic t_disable();
    wr({24'h0, fld(6, 1, 1, 1)});
    pin_bus[6] = 1'b1;
    tick(3);
    check("R7", "armed before disable", {31'h0, irq_pend[0]}, 32'h1);
    wr({24'h0, fld(6, 1, 1, 0)});
    tick(1);
    check("R10", "disable drops flag", {31'h0, irq_pend[0]}, 32'h0);
    wr({24'h0, fld(6, 1, 3, 1)});
    pin_bus[6] = 1'b0;
    tick(3);
    pin_bus[6] = 1'b1;
    tick(3);
    check("R10", "mode 3 quiet", {31'h0, irq_pend[0]}, 32'h0);
    wr({24'h0, fld(6, 1, 0, 0)});
    tick(2);
    check("R10", "level disabled quiet", {31'h0, irq_pend[0]}, 32'h0);
    quiesce();
  endtask

  task automatic t_select();
    pin_bus[7] = 1'b1;
    tick(3);
    wr({24'h0, fld(2, 0, 2, 1)});
    tick(1);
    check("R11", "stable start", {31'h0, irq_pend[0]}, 32'h0);
    wr({24'h0, fld(7, 0, 2, 1)});
    tick(3);
    check("R11", "switch is not an edge", {31'h0, irq_pend[0]}, 32'h0);
    pin_bus[7] = 1'b0;
    tick(3);
    check("R3", "new pin seen", {31'h0, irq_pend[0]}, 32'h1);
    clr(0);
    pin_bus[2] = 1'b1;
    pin_bus[15] = 1'b1;
    tick(3);
    check("R3", "other pins ignored", {31'h0, irq_pend[0]}, 32'h0);
    quiesce();
  endtask

  task automatic t_chan1();
    wr({16'h0, fld(9, 1, 1, 1), fld(9, 0, 2, 1)});
    tick(1);
    pin_bus[25] = 1'b1;
    tick(3);
    check("R12", "only channel 1 set", {30'h0, irq_pend}, 32'h2);
    clr(0);
    check("R12", "clear 0 spares channel 1", {30'h0, irq_pend}, 32'h2);
    clr(1);
    check("R9", "channel 1 cleared", {30'h0, irq_pend}, 32'h0);
    pin_bus[9] = 1'b1;
    tick(3);
    check("R12", "only channel 0 set", {30'h0, irq_pend}, 32'h1);
    quiesce();
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = '0; pend_clr = '0; pin_bus = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_dual();
    t_disable();
    t_select();
    t_chan1();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule